// File: doc/BRIEF.md
# Host Byte Port

This block is a slave port that lets an external host exchange bytes with on-chip logic over an asynchronous 8-bit parallel bus. One address line picks between two register pairs. With the line low, the host writes an inbound byte and reads the outbound byte. With the line high, the host reads a status byte or writes a control byte. Chip select, read strobe and write strobe are active low. An interrupt line tells the host that an outbound byte is waiting.

The host strobes are not related to the internal clock. Each one passes through a two-flop synchroniser. A register action takes effect on the synchronised rising edge of a strobe, and only if chip select was seen low while that strobe was low. Address and write data are captured in the cycles while the strobe is held low. The internal side sees an inbound byte with a valid flag, which it drops with a one-cycle consume pulse. It loads the outbound byte with a one-cycle load pulse. A host control write appears as a byte with a one-cycle strobe.

Top module: `hbp_top`

## Requirements
- R1: After reset, `host_irq`, `rx_valid`, `ovr_flag` and `ctl_stb` are 0, and the status byte reads 0xBF.
- R2: `host_d_oe` is 1 only while `host_cs_n` and `host_rd_n` are both low, and 0 at every other time.
- R3: A host write with `host_sel`=0 to an empty receive register puts the byte on `rx_data` and sets `rx_valid`. Both appear at the third clock edge after the write strobe rises.
- R4: A host write with `host_sel`=1 puts the byte on `ctl_data` and pulses `ctl_stb` for exactly one cycle. It leaves `rx_data` and `rx_valid` unchanged.
- R5: A read with `host_sel`=1 returns the status byte. Bit 7 is transmit-empty: it is 0 while an outbound byte is pending. Bit 6 is receiver-full: it is 1 while an inbound byte is unconsumed and 0 when a new byte can be accepted. Bits 5..0 read 1.
- R6: A `tx_load` pulse stores `tx_data`, raises `host_irq` at the next edge and clears transmit-empty. A host read with `host_sel`=0 returns the stored byte.
- R7: A completed host read with `host_sel`=0 clears `host_irq` and sets transmit-empty again. A status read leaves both unchanged.
- R8: An `rx_take` pulse clears `rx_valid` at the next edge, so receiver-full reads 0 again.
- R9: A host data write while `rx_valid` is 1 is dropped: `rx_data` is kept. It also sets `ovr_flag`, which then stays 1 until reset.
- R10: A strobe pulse while `host_cs_n` is high changes no register and produces no `ctl_stb`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst | input | 1 | Synchronous reset, active high |
| host_cs_n | input | 1 | Host chip select, active low |
| host_rd_n | input | 1 | Host read strobe, active low |
| host_wr_n | input | 1 | Host write strobe, active low |
| host_sel | input | 1 | Register pair select: 0 data, 1 status/control |
| host_d_i | input | 8 | Host bus, write direction |
| host_d_o | output | 8 | Host bus, read direction |
| host_d_oe | output | 1 | Drive enable for the host bus |
| host_irq | output | 1 | High while an outbound byte is pending |
| rx_data | output | 8 | Last accepted inbound byte |
| rx_valid | output | 1 | Inbound byte not yet consumed |
| rx_take | input | 1 | One-cycle consume pulse |
| tx_data | input | 8 | Outbound byte |
| tx_load | input | 1 | One-cycle load pulse for tx_data |
| ctl_data | output | 8 | Last control byte |
| ctl_stb | output | 1 | One-cycle pulse on a control write |
| ovr_flag | output | 1 | Sticky: a data write was dropped |

## Verification
Every host-side result becomes visible at the third rising edge after the strobe rises: two synchroniser stages, then the edge compare. Internal pulses act at the very next edge. The bus tasks hold address, data and chip select for four cycles after releasing the strobe, and return only after that. Direct checks therefore sample on falling edges past the due edge. A scoreboard queue holds each expected inbound or control byte, and a falling-edge monitor pops the queue whenever `ctl_stb` pulses or `rx_valid` rises. An event with no queued entry, or a byte left in the queue, is counted as a failure. Host writes are spaced 130 cycles apart.

// File: rtl/hbp_pkg.sv
package hbp_pkg;
  localparam int unsigned HBP_TE_BIT = 7;
  localparam int unsigned HBP_RF_BIT = 6;

  typedef enum logic {
    SEL_DATA = 1'b0,
    SEL_CTRL = 1'b1
  } hbp_sel_e;
endpackage

// File: rtl/hbp_sync.sv
module hbp_sync #(
  parameter int unsigned STAGES = 2,
  parameter int unsigned NSIG   = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSIG-1:0] async_i,
  output logic [NSIG-1:0] lvl_o,
  output logic [NSIG-1:0] rise_o
);
  localparam int unsigned LAST = STAGES - 1;

  for (genvar i = 0; i < NSIG; i++) begin : g_sig
    logic [STAGES-1:0] chain;
    logic              prev;

    always_ff @(posedge clk) begin
      if (rst) begin
        chain <= '1;
        prev  <= 1'b1;
      end else begin
        chain <= {chain[STAGES-2:0], async_i[i]};
        prev  <= chain[LAST];
      end
    end

    assign lvl_o[i]  = chain[LAST];
    assign rise_o[i] = chain[LAST] & ~prev;

    // R3: a detected edge never lasts two cycles
    a_r3_single_edge: assert property (@(posedge clk) disable iff (rst)
      rise_o[i] |=> !rise_o[i]);
  end
endmodule

// File: rtl/hbp_front.sv
module hbp_front #(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cs_lvl,
  input  logic          rd_lvl,
  input  logic          wr_lvl,
  input  logic          rd_rise,
  input  logic          wr_rise,
  input  logic          sel_raw,
  input  logic [DW-1:0] din_raw,
  output logic          wr_go,
  output logic          wr_sel,
  output logic [DW-1:0] wr_byte,
  output logic          rd_go,
  output logic          rd_sel
);
  logic wr_arm, rd_arm;

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_arm  <= 1'b0;
      wr_sel  <= 1'b0;
      wr_byte <= '0;
    end else if (!wr_lvl && !cs_lvl) begin
      wr_arm  <= 1'b1;
      wr_sel  <= sel_raw;
      wr_byte <= din_raw;
    end else if (wr_rise) begin
      wr_arm <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_arm <= 1'b0;
      rd_sel <= 1'b0;
    end else if (!rd_lvl && !cs_lvl) begin
      rd_arm <= 1'b1;
      rd_sel <= sel_raw;
    end else if (rd_rise) begin
      rd_arm <= 1'b0;
    end
  end

  assign wr_go = wr_rise & wr_arm;
  assign rd_go = rd_rise & rd_arm;

  // R10: no commit unless the strobe was seen with chip select low
  a_r10_armed_only: assert property (@(posedge clk) disable iff (rst)
    wr_rise && !wr_arm |-> !wr_go);
endmodule

// File: rtl/hbp_regs.sv
module hbp_regs
  import hbp_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_go,
  input  logic          wr_sel,
  input  logic [DW-1:0] wr_byte,
  input  logic          rd_go,
  input  logic          rd_sel,
  input  logic          rx_take,
  input  logic          tx_load,
  input  logic [DW-1:0] tx_data,
  output logic [DW-1:0] rx_data,
  output logic          rx_valid,
  output logic          ovr_flag,
  output logic [DW-1:0] ctl_data,
  output logic          ctl_stb,
  output logic          tx_pend,
  output logic [DW-1:0] tx_byte,
  output logic [DW-1:0] status
);
  localparam int unsigned PAD = DW - 2;

  logic wr_data_go, wr_ctrl_go, rd_data_go;
  assign wr_data_go = wr_go && (hbp_sel_e'(wr_sel) == SEL_DATA);
  assign wr_ctrl_go = wr_go && (hbp_sel_e'(wr_sel) == SEL_CTRL);
  assign rd_data_go = rd_go && (hbp_sel_e'(rd_sel) == SEL_DATA);

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_data  <= '0;
      rx_valid <= 1'b0;
      ovr_flag <= 1'b0;
    end else begin
      if (wr_data_go && (!rx_valid || rx_take)) begin
        rx_data  <= wr_byte;
        rx_valid <= 1'b1;
      end else if (rx_take) begin
        rx_valid <= 1'b0;
      end
      if (wr_data_go && rx_valid && !rx_take) ovr_flag <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_data <= '0;
      ctl_stb  <= 1'b0;
    end else begin
      ctl_stb <= wr_ctrl_go;
      if (wr_ctrl_go) ctl_data <= wr_byte;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_pend <= 1'b0;
      tx_byte <= '0;
    end else if (tx_load) begin
      tx_pend <= 1'b1;
      tx_byte <= tx_data;
    end else if (rd_data_go) begin
      tx_pend <= 1'b0;
    end
  end

  assign status = {~tx_pend, rx_valid, {PAD{1'b1}}};

  a_r6_load_raises_irq: assert property (@(posedge clk) disable iff (rst)
    tx_load |=> tx_pend);
  a_r7_read_clears_irq: assert property (@(posedge clk) disable iff (rst)
    rd_data_go && !tx_load |=> !tx_pend);
  a_r4_ctl_pulse_once: assert property (@(posedge clk) disable iff (rst)
    ctl_stb |=> !ctl_stb);
  a_r8_take_clears: assert property (@(posedge clk) disable iff (rst)
    rx_take && !wr_data_go |=> !rx_valid);
  a_r9_ovr_sticky: assert property (@(posedge clk) disable iff (rst)
    ovr_flag |=> ovr_flag);
  a_r9_drop_keeps: assert property (@(posedge clk) disable iff (rst)
    wr_data_go && rx_valid && !rx_take |=> $stable(rx_data));
endmodule

// File: rtl/hbp_top.sv
module hbp_top #(
  parameter int unsigned DW     = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          host_cs_n,
  input  logic          host_rd_n,
  input  logic          host_wr_n,
  input  logic          host_sel,
  input  logic [DW-1:0] host_d_i,
  output logic [DW-1:0] host_d_o,
  output logic          host_d_oe,
  output logic          host_irq,
  output logic [DW-1:0] rx_data,
  output logic          rx_valid,
  input  logic          rx_take,
  input  logic [DW-1:0] tx_data,
  input  logic          tx_load,
  output logic [DW-1:0] ctl_data,
  output logic          ctl_stb,
  output logic          ovr_flag
);
  localparam int unsigned NSIG = 3;

  logic [NSIG-1:0] lvl, rise;
  logic            wr_go, wr_sel, rd_go, rd_sel, tx_pend;
  logic [DW-1:0]   wr_byte, tx_byte, status;

  hbp_sync #(.STAGES(STAGES), .NSIG(NSIG)) u_sync (
    .clk(clk), .rst(rst),
    .async_i({host_wr_n, host_rd_n, host_cs_n}),
    .lvl_o(lvl), .rise_o(rise)
  );

  hbp_front #(.DW(DW)) u_front (
    .clk(clk), .rst(rst),
    .cs_lvl(lvl[0]), .rd_lvl(lvl[1]), .wr_lvl(lvl[2]),
    .rd_rise(rise[1]), .wr_rise(rise[2]),
    .sel_raw(host_sel), .din_raw(host_d_i),
    .wr_go(wr_go), .wr_sel(wr_sel), .wr_byte(wr_byte),
    .rd_go(rd_go), .rd_sel(rd_sel)
  );

  hbp_regs #(.DW(DW)) u_regs (
    .clk(clk), .rst(rst),
    .wr_go(wr_go), .wr_sel(wr_sel), .wr_byte(wr_byte),
    .rd_go(rd_go), .rd_sel(rd_sel),
    .rx_take(rx_take), .tx_load(tx_load), .tx_data(tx_data),
    .rx_data(rx_data), .rx_valid(rx_valid), .ovr_flag(ovr_flag),
    .ctl_data(ctl_data), .ctl_stb(ctl_stb),
    .tx_pend(tx_pend), .tx_byte(tx_byte), .status(status)
  );

  assign host_d_oe = ~host_cs_n & ~host_rd_n;
  assign host_d_o  = host_sel ? status : tx_byte;
  assign host_irq  = tx_pend;

  // R2: bus released whenever chip select is high
  a_r2_bus_release: assert property (@(posedge clk) disable iff (rst)
    host_cs_n |-> !host_d_oe);
endmodule

// File: tb/tb_hbp_top.sv
module tb_hbp_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       host_cs_n = 1'b1, host_rd_n = 1'b1, host_wr_n = 1'b1, host_sel = 1'b0;
  logic [7:0] host_d_i = '0, tx_data = '0;
  logic       rx_take = 1'b0, tx_load = 1'b0;
  logic [7:0] host_d_o, rx_data, ctl_data;
  logic       host_d_oe, host_irq, rx_valid, ctl_stb, ovr_flag;

  int n_chk = 0, n_fail = 0;
  logic [8:0] exp_q[$];
  logic       rxv_prev = 1'b0;
  logic       done = 1'b0;

  always #2 clk = ~clk;

  hbp_top dut (.*);

  task automatic chk(string tag, logic [7:0] got, logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  // scoreboard monitor: bit8 = 1 control byte, 0 inbound byte
  always @(negedge clk) begin
    if (!rst) begin
      if (ctl_stb) begin
        if (exp_q.size() == 0) chk("R10 unexpected ctl_stb", {7'd0, ctl_stb}, 8'h00);
        else begin
          logic [8:0] e;
          e = exp_q.pop_front();
          chk("R4 ctl scoreboard", {e[8], ctl_data[6:0]}, {1'b1, e[6:0]});
          chk("R4 ctl byte", ctl_data, e[7:0]);
        end
      end
      if (rx_valid && !rxv_prev) begin
        if (exp_q.size() == 0) chk("R10 unexpected rx_valid", 8'h01, 8'h00);
        else begin
          logic [8:0] e;
          e = exp_q.pop_front();
          chk("R3 rx scoreboard kind", {7'd0, e[8]}, 8'h00);
          chk("R3 rx byte", rx_data, e[7:0]);
        end
      end
    end
    rxv_prev <= rx_valid;
  end

  task automatic host_wr(logic sel, logic [7:0] b, logic cs_n);
    @(negedge clk);
    host_sel = sel; host_d_i = b; host_cs_n = cs_n;
    @(negedge clk);
    host_wr_n = 1'b0;
    repeat (4) @(negedge clk);
    host_wr_n = 1'b1;
    repeat (4) @(negedge clk);
    host_cs_n = 1'b1;
    repeat (120) @(negedge clk);
  endtask

  task automatic host_rd(logic sel, output logic [7:0] b);
    @(negedge clk);
    host_sel = sel; host_cs_n = 1'b0;
    @(negedge clk);
    host_rd_n = 1'b0;
    repeat (4) @(negedge clk);
    b = host_d_o;
    chk("R2 oe during read", {7'd0, host_d_oe}, 8'h01);
    host_rd_n = 1'b1;
    repeat (4) @(negedge clk);
    host_cs_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R2 oe after read", {7'd0, host_d_oe}, 8'h00);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired got=running exp=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin : stim
    logic [7:0] v;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 irq", {7'd0, host_irq}, 8'h00);
    chk("R1 rx_valid", {7'd0, rx_valid}, 8'h00);
    chk("R1 ovr", {7'd0, ovr_flag}, 8'h00);
    chk("R1 ctl_stb", {7'd0, ctl_stb}, 8'h00);
    chk("R2 oe idle", {7'd0, host_d_oe}, 8'h00);
    host_rd(1'b1, v); chk("R1 R5 status reset", v, 8'hBF);

    exp_q.push_back({1'b0, 8'h5A});
    host_wr(1'b0, 8'h5A, 1'b0);
    chk("R3 rx_data", rx_data, 8'h5A);
    chk("R3 rx_valid", {7'd0, rx_valid}, 8'h01);
    host_rd(1'b1, v); chk("R5 status full", v, 8'hFF);

    exp_q.push_back({1'b1, 8'h3C});
    host_wr(1'b1, 8'h3C, 1'b0);
    chk("R4 ctl_data", ctl_data, 8'h3C);
    chk("R4 rx kept", rx_data, 8'h5A);

    host_wr(1'b0, 8'h11, 1'b0);
    chk("R9 drop keeps", rx_data, 8'h5A);
    chk("R9 ovr set", {7'd0, ovr_flag}, 8'h01);

    @(negedge clk); rx_take = 1'b1;
    @(negedge clk); rx_take = 1'b0;
    chk("R8 take clears", {7'd0, rx_valid}, 8'h00);
    chk("R9 ovr sticky", {7'd0, ovr_flag}, 8'h01);
    host_rd(1'b1, v); chk("R8 status empty", v, 8'hBF);

    host_wr(1'b0, 8'h77, 1'b1);
    host_wr(1'b1, 8'h66, 1'b1);
    chk("R10 rx untouched", {7'd0, rx_valid}, 8'h00);
    chk("R10 ctl untouched", ctl_data, 8'h3C);

    @(negedge clk); tx_data = 8'hA5; tx_load = 1'b1;
    @(negedge clk); tx_load = 1'b0; tx_data = 8'h00;
    chk("R6 irq raised", {7'd0, host_irq}, 8'h01);
    host_rd(1'b1, v); chk("R5 R6 status pending", v, 8'h3F);
    chk("R7 status read keeps irq", {7'd0, host_irq}, 8'h01);
    host_rd(1'b0, v); chk("R6 tx byte", v, 8'hA5);
    chk("R7 irq cleared", {7'd0, host_irq}, 8'h00);
    host_rd(1'b1, v); chk("R7 status te", v, 8'hBF);

    exp_q.push_back({1'b0, 8'hC3});
    host_wr(1'b0, 8'hC3, 1'b0);
    chk("R3 second byte", rx_data, 8'hC3);

    repeat (4) @(negedge clk);
    chk("R3 R4 scoreboard drained", 8'(exp_q.size()), 8'h00);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule